// File: doc/BRIEF.md
# Data Cache Sweep Sequencer

This block walks every entry of a segmented data cache's tag and status array in one pass. At each entry it either cleans the entry or cleans and invalidates it. Cleaning means a line holding modified data that memory has not yet received is written back, and its dirty bit is then cleared. A pulse on `sweep_start` launches a pass. The level on `sweep_inval` at that moment chooses between clean-only and clean-plus-invalidate. A pulse on `drop_all` launches a pass that clears every entry and discards modified data without writing it back.

The cache side of the block has one status port. The sequencer drives an 8-bit entry address, and the cache returns that entry's valid bit, dirty bit, stored tag and full line data in the same cycle. Status updates go back through a write strobe. Write-backs leave on a valid/ready request channel, which carries a rebuilt byte address and the line as one wide word. `sweep_busy` covers the whole pass, and `sweep_done` pulses once at the end of it.

Top module: `dcache_sweep`

## Requirements
- R1: Entries are visited with the segment as the outer loop and the index as the inner loop. The order is segment 0 indices 0..63, then segment 1, and so on up to segment 3. `st_addr` is {segment[1:0], index[5:0]}.
- R2: When `sweep_inval`=0 at start, a valid dirty entry is written back and then updated to valid=1, dirty=0. A valid clean entry produces no write-back and no status write.
- R3: When `sweep_inval`=1 at start, a valid dirty entry is written back and then updated to valid=0, dirty=0. A valid clean entry is updated to valid=0, dirty=0 with no write-back.
- R4: During a clean or clean-and-invalidate pass, an invalid entry takes one cycle. It causes no write-back and no status write, whatever its dirty bit holds.
- R5: A `drop_all` pass writes valid=0, dirty=0 to all 256 entries, one entry per cycle, and issues no write-back.
- R6: The write-back address is {tag, segment, index, 5'b0}. The write-back data is the entry's full line word.
- R7: While `wb_valid`=1 and `wb_ready`=0, the sequencer holds the request with `wb_addr` and `wb_data` stable. It writes no status and does not advance. The status write and the advance happen in the cycle the handshake completes.
- R8: `sweep_busy` rises the cycle after an accepted command and stays high until the last entry (segment 3, index 63) is processed. It then falls in the same cycle that `sweep_done` pulses high for exactly one cycle. With `wb_ready` held high, a pass keeps `sweep_busy` high for 256 cycles plus one cycle per written-back entry.
- R9: `sweep_start` and `drop_all` are ignored while busy. When both are asserted while idle, `drop_all` takes priority.
- R10: A synchronous reset returns the block to idle, with busy, done and `wb_valid` low and the entry counter at zero. Reset itself writes no cache status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sweep_start | input | 1 | Launch a clean pass (pulse) |
| sweep_inval | input | 1 | Sampled with start: 1 = clean and invalidate, 0 = clean only |
| drop_all | input | 1 | Launch a whole-cache invalidate pass without write-back (pulse) |
| sweep_busy | output | 1 | A pass is in progress |
| sweep_done | output | 1 | One-cycle pulse after the last entry |
| st_addr | output | 8 | Entry address {segment, index} |
| st_valid_i | input | 1 | Valid bit of the addressed entry |
| st_dirty_i | input | 1 | Dirty bit of the addressed entry |
| st_tag_i | input | 19 | Stored tag of the addressed entry |
| line_i | input | 256 | Line data of the addressed entry |
| st_we | output | 1 | Status write strobe for the addressed entry |
| st_valid_o | output | 1 | Valid bit to write |
| st_dirty_o | output | 1 | Dirty bit to write |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | 32 | Write-back byte address |
| wb_data | output | 256 | Write-back line data |

## Verification
The assertions watch several rules on every cycle:
- a stalled write-back holds its request steady and writes no status;
- a write-back begins only on a valid dirty entry;
- an invalid entry is passed over without traffic;
- a clean-only pass never clears a valid bit;
- a drop pass never raises a request;
- the entry counter steps through the segment/index order and wraps;
- done is a lone pulse outside busy.

Other behaviours only show up in the bench's scenarios, which compare against a model cache:
- the full write-back sequence and its rebuilt addresses;
- the final state of all 256 entries in each mode;
- exact pass lengths;
- that commands arriving mid-pass are ignored;
- that a reset in the middle of a stall leaves the cache untouched.

// File: rtl/dcache_sweep_pkg.sv
package dcache_sweep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_WB   = 2'd2
    } sweep_state_e;

    typedef enum logic [1:0] {
        OP_CLEAN   = 2'd0,
        OP_CINV    = 2'd1,
        OP_DROPALL = 2'd2
    } sweep_op_e;

endpackage

// File: rtl/dcache_sweep_ctr.sv
module dcache_sweep_ctr #(
    parameter int SEG_W = 2,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [SEG_W-1:0] seg_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam int ENT_W = SEG_W + IDX_W;
    localparam logic [SEG_W-1:0] SEG_MAX = {SEG_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [IDX_W-1:0] idx;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d = '0;
        end else if (adv) begin
            if (ctr_q.idx == IDX_MAX) begin
                ctr_d.idx = '0;
                ctr_d.seg = ctr_q.seg + 1'b1;
            end else begin
                ctr_d.idx = ctr_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign seg_o  = ctr_q.seg;
    assign idx_o  = ctr_q.idx;
    assign last_o = (ctr_q.seg == SEG_MAX) && (ctr_q.idx == IDX_MAX);

    // R1: inner index steps, carrying into the segment
    assert_walk_order_R1: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && !last_o) |=>
            ({seg_o, idx_o} == ENT_W'($past({seg_o, idx_o}) + 1'b1)));

    // R1: after the final entry the walk returns to entry zero
    assert_walk_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (adv && last_o) |=> (seg_o == '0 && idx_o == '0));

endmodule

// File: rtl/dcache_sweep_rule.sv
module dcache_sweep_rule
    import dcache_sweep_pkg::*;
(
    input  sweep_op_e op,
    input  logic      valid,
    input  logic      dirty,
    output logic      need_wb,
    output logic      direct_wr,
    output logic      keep_valid
);
    always_comb begin
        need_wb    = 1'b0;
        direct_wr  = 1'b0;
        keep_valid = 1'b0;
        unique case (op)
            OP_CLEAN: begin
                need_wb    = valid & dirty;
                keep_valid = 1'b1;
            end
            OP_CINV: begin
                need_wb    = valid & dirty;
                direct_wr  = valid & ~dirty;
            end
            OP_DROPALL: begin
                direct_wr  = 1'b1;
            end
            default: begin
                need_wb    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dcache_sweep.sv
module dcache_sweep
    import dcache_sweep_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 19,
    parameter int OFFS_W = 5,
    parameter int LINE_W = 256
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sweep_start,
    input  logic                              sweep_inval,
    input  logic                              drop_all,
    output logic                              sweep_busy,
    output logic                              sweep_done,
    output logic [SEG_W+IDX_W-1:0]            st_addr,
    input  logic                              st_valid_i,
    input  logic                              st_dirty_i,
    input  logic [TAG_W-1:0]                  st_tag_i,
    input  logic [LINE_W-1:0]                 line_i,
    output logic                              st_we,
    output logic                              st_valid_o,
    output logic                              st_dirty_o,
    output logic                              wb_valid,
    input  logic                              wb_ready,
    output logic [TAG_W+SEG_W+IDX_W+OFFS_W-1:0] wb_addr,
    output logic [LINE_W-1:0]                 wb_data
);
    localparam int ADDR_W = TAG_W + SEG_W + IDX_W + OFFS_W;

    typedef struct packed {
        sweep_state_e      st;
        sweep_op_e         op;
        logic [ADDR_W-1:0] wb_addr;
        logic [LINE_W-1:0] wb_data;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             ctr_clr, ctr_adv, ctr_last;
    logic [SEG_W-1:0] cur_seg;
    logic [IDX_W-1:0] cur_idx;
    logic             need_wb, direct_wr, keep_valid;

    dcache_sweep_ctr #(.SEG_W(SEG_W), .IDX_W(IDX_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctr_clr),
        .adv    (ctr_adv),
        .seg_o  (cur_seg),
        .idx_o  (cur_idx),
        .last_o (ctr_last)
    );

    dcache_sweep_rule u_rule (
        .op         (seq_q.op),
        .valid      (st_valid_i),
        .dirty      (st_dirty_i),
        .need_wb    (need_wb),
        .direct_wr  (direct_wr),
        .keep_valid (keep_valid)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ctr_clr    = 1'b0;
        ctr_adv    = 1'b0;
        st_we      = 1'b0;
        st_valid_o = 1'b0;
        st_dirty_o = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (drop_all) begin
                    seq_d.op = OP_DROPALL;
                    seq_d.st = ST_WALK;
                    ctr_clr  = 1'b1;
                end else if (sweep_start) begin
                    seq_d.op = sweep_inval ? OP_CINV : OP_CLEAN;
                    seq_d.st = ST_WALK;
                    ctr_clr  = 1'b1;
                end
            end
            ST_WALK: begin
                if (need_wb) begin
                    seq_d.st      = ST_WB;
                    seq_d.wb_addr = {st_tag_i, cur_seg, cur_idx, {OFFS_W{1'b0}}};
                    seq_d.wb_data = line_i;
                end else begin
                    st_we      = direct_wr;
                    st_valid_o = keep_valid;
                    ctr_adv    = 1'b1;
                    if (ctr_last) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_WB: begin
                if (wb_ready) begin
                    st_we      = 1'b1;
                    st_valid_o = keep_valid;
                    ctr_adv    = 1'b1;
                    if (ctr_last) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st   = ST_WALK;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign sweep_busy = (seq_q.st != ST_IDLE);
    assign sweep_done = seq_q.done;
    assign st_addr    = {cur_seg, cur_idx};
    assign wb_valid   = (seq_q.st == ST_WB);
    assign wb_addr    = seq_q.wb_addr;
    assign wb_data    = seq_q.wb_data;

    // R7: a stalled request stays put and nothing is written back to status
    assert_wb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=>
            (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    assert_stall_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |-> !st_we);

    // R2: a request is only raised for an entry that was valid and dirty
    assert_wb_only_dirty_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_valid) |-> $past(st_valid_i && st_dirty_i));

    // R2: a clean-only pass keeps lines valid and clears dirty
    assert_clean_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (sweep_busy && seq_q.op == OP_CLEAN && st_we) |-> (st_valid_o && !st_dirty_o));

    // R4: an invalid entry in a clean pass is passed over without traffic
    assert_skip_invalid_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_WALK && seq_q.op != OP_DROPALL && !st_valid_i) |->
            (!st_we ##1 !wb_valid));

    // R5: a drop pass never raises a write-back
    assert_drop_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_q.op == OP_DROPALL) |-> !wb_valid);

    // R8: done is a single pulse outside busy
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> (!sweep_busy ##1 !sweep_done));

endmodule

// File: tb/dcache_sweep_tb.sv
`timescale 1ns/1ps
module dcache_sweep_tb;
    localparam int NENT = 256;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst, sweep_start, sweep_inval, drop_all;
    logic         sweep_busy, sweep_done;
    logic [7:0]   st_addr;
    logic         st_valid_i, st_dirty_i;
    logic [18:0]  st_tag_i;
    logic [255:0] line_i;
    logic         st_we, st_valid_o, st_dirty_o;
    logic         wb_valid, wb_ready;
    logic [31:0]  wb_addr;
    logic [255:0] wb_data;

    dcache_sweep u_dut (
        .clk(clk), .rst(rst), .sweep_start(sweep_start), .sweep_inval(sweep_inval),
        .drop_all(drop_all), .sweep_busy(sweep_busy), .sweep_done(sweep_done),
        .st_addr(st_addr), .st_valid_i(st_valid_i), .st_dirty_i(st_dirty_i),
        .st_tag_i(st_tag_i), .line_i(line_i), .st_we(st_we), .st_valid_o(st_valid_o),
        .st_dirty_o(st_dirty_o), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // model cache array
    logic         mv [NENT];
    logic         md [NENT];
    logic [18:0]  mt [NENT];
    logic [255:0] ml [NENT];
    // expected snapshot and captured write-backs
    logic         ev [NENT];
    logic         ed [NENT];
    logic [31:0]  ga [NENT];
    logic [255:0] gd [NENT];
    int           gcnt;
    logic         gclr = 1'b0;
    logic         fill_req = 1'b0;
    int unsigned  fill_salt, fill_pv, fill_pd;
    int unsigned  rdy_pct = 100;

    int tests = 0, fails = 0;

    assign st_valid_i = mv[st_addr];
    assign st_dirty_i = md[st_addr];
    assign st_tag_i   = mt[st_addr];
    assign line_i     = ml[st_addr];

    function automatic int unsigned mix(int unsigned x);
        x = x ^ (x >> 16); x = x * 32'h7feb352d;
        x = x ^ (x >> 15); x = x * 32'h846ca68b;
        return x ^ (x >> 16);
    endfunction

    function automatic logic [255:0] line_of(int unsigned salt, int e);
        logic [255:0] w;
        for (int k = 0; k < 8; k++) w[k*32 +: 32] = mix(salt + e * 8 + k);
        return w;
    endfunction

    always @(posedge clk) begin
        if (fill_req) begin
            for (int e = 0; e < NENT; e++) begin
                mv[e] <= (mix(fill_salt ^ e) % 100) < fill_pv;
                md[e] <= (mix(fill_salt + 32'h1000 + e) % 100) < fill_pd;
                mt[e] <= 19'(mix(fill_salt + 32'h2000 + e));
                ml[e] <= line_of(fill_salt, e);
            end
        end else if (st_we) begin
            mv[st_addr] <= st_valid_o;
            md[st_addr] <= st_dirty_o;
        end
        if (gclr) gcnt <= 0;
        else if (wb_valid && wb_ready) begin
            if (gcnt < NENT) begin
                ga[gcnt] <= wb_addr;
                gd[gcnt] <= wb_data;
            end
            gcnt <= gcnt + 1;
        end
    end

    always @(negedge clk) wb_ready <= (($urandom % 100) < rdy_pct);

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill(int unsigned pv, int unsigned pd);
        @(negedge clk);
        fill_salt = $urandom; fill_pv = pv; fill_pd = pd; fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    // op: 0 clean, 1 clean+invalidate, 2 drop all, 3 start and drop_all together
    task automatic run(int op, int unsigned pct, bit poke);
        int exp_n = 0, cyc = 0, bad = 0, first_bad = -1, bad_st = 0;
        logic [31:0]  xa [NENT];
        logic [255:0] xd [NENT];
        bit drop = (op >= 2);
        string rq = drop ? "R5" : (op == 1 ? "R3" : "R2");
        rdy_pct = pct;
        for (int e = 0; e < NENT; e++) begin
            ev[e] = mv[e]; ed[e] = md[e];
            if (!drop && mv[e] && md[e]) begin
                xa[exp_n] = {mt[e], 8'(e), 5'b0};
                xd[exp_n] = ml[e];
                exp_n++;
            end
        end
        @(negedge clk);
        gclr = 1'b1;
        @(negedge clk);
        gclr = 1'b0;
        sweep_start = (op != 2);
        sweep_inval = (op == 1);
        drop_all    = (op >= 2);
        @(negedge clk);
        sweep_start = 1'b0; drop_all = 1'b0;
        while (!sweep_done && cyc < 20000) begin
            if (sweep_busy) cyc++;
            if (poke && cyc == 20) begin
                sweep_start = 1'b1; sweep_inval = ~sweep_inval; drop_all = 1'b1;
            end else begin
                sweep_start = 1'b0; drop_all = 1'b0;
            end
            @(negedge clk);
        end
        sweep_start = 1'b0; drop_all = 1'b0;
        chk(sweep_done && !sweep_busy, "R8", "done with busy low", sweep_busy, 0);
        @(negedge clk);
        chk(!sweep_done && !sweep_busy, "R8", "done lasts one cycle", sweep_done, 0);
        chk(gcnt == exp_n, rq, "write-back count", gcnt, exp_n);
        for (int i = 0; i < exp_n && i < gcnt; i++)
            if (ga[i] !== xa[i] || gd[i] !== xd[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        chk(bad == 0, "R1 R6", "write-back order/address/data",
            first_bad < 0 ? 0 : ga[first_bad], first_bad < 0 ? 0 : xa[first_bad]);
        for (int e = 0; e < NENT; e++) begin
            logic xv, xdy;
            if (drop)          begin xv = 1'b0;  xdy = 1'b0; end
            else if (!ev[e])   begin xv = 1'b0;  xdy = ed[e]; end // R4: untouched
            else               begin xv = (op == 0); xdy = 1'b0; end
            if (mv[e] !== xv || md[e] !== xdy) bad_st++;
        end
        chk(bad_st == 0, poke ? "R9" : (drop ? "R5" : "R2 R3 R4"),
            "entries with wrong final status", bad_st, 0);
        if (pct == 100)
            chk(cyc == NENT + exp_n, "R8", "busy cycles", cyc, NENT + exp_n);
        else
            chk(cyc >= NENT + exp_n, "R7", "busy cycles with stalls", cyc, NENT + exp_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int sc;
        void'($urandom(32'd20240611));
        rst = 1'b1; sweep_start = 1'b0; sweep_inval = 1'b0; drop_all = 1'b0;
        fill(60, 50);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(!sweep_busy && !sweep_done && !wb_valid && !st_we && st_addr == 0,
            "R10", "idle after reset", {sweep_busy, sweep_done, wb_valid, st_we}, 0);

        // directed: clean only with full readiness (R2, R4, R8)
        run(0, 100, 0);
        // directed: second clean pass finds nothing dirty (R2)
        run(0, 100, 0);
        // directed: clean and invalidate (R3)
        fill(70, 40);
        run(1, 100, 0);
        // directed: all invalid with dirty bits set (R4)
        fill(0, 100);
        run(1, 100, 0);
        // directed: drop all with dirty data (R5)
        fill(90, 90);
        run(2, 100, 0);
        // directed: start and drop_all together in idle, drop wins (R9)
        fill(80, 60);
        run(3, 100, 0);
        // directed: commands while busy are ignored (R9)
        fill(60, 50);
        run(0, 100, 1);
        // directed: stalled memory (R7)
        fill(100, 100);
        run(1, 30, 0);

        // R10: reset while stalled on a write-back leaves the cache intact
        fill(100, 100);
        rdy_pct = 0;
        @(negedge clk);
        sweep_start = 1'b1; sweep_inval = 1'b1;
        @(negedge clk);
        sweep_start = 1'b0;
        repeat (8) @(negedge clk);
        for (int e = 0; e < NENT; e++) begin ev[e] = mv[e]; ed[e] = md[e]; end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sweep_busy && !wb_valid && !sweep_done, "R10", "idle after mid-pass reset",
            {sweep_busy, wb_valid}, 0);
        sc = 0;
        for (int e = 0; e < NENT; e++) if (mv[e] !== ev[e] || md[e] !== ed[e]) sc++;
        chk(sc == 0, "R10", "entries changed by reset", sc, 0);
        chk(st_addr == 0, "R10", "entry counter after reset", st_addr, 0);
        run(0, 100, 0);

        // constrained random passes
        for (int r = 0; r < 6; r++) begin
            fill($urandom % 101, $urandom % 101);
            run($urandom % 4, 40 + ($urandom % 61), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule